// File: doc/BRIEF.md
# Register-File LIFO Stack

This block is a last-in first-out store built from a small register file and a wrapping stack pointer. A push strobe stores one data word. A pop strobe returns the most recently stored word. The block holds no separate occupancy counter. Whether the stack is full or empty is decided only by the pointer wrapping to zero. The full and empty flags record which direction the pointer was moving when it wrapped.

A push moves the pointer up by one and then writes the word into the slot the pointer now names. A pop reads the slot the pointer names and then moves the pointer down by one. The stack therefore uses slots 1 to 2^PTR_W-1 first and slot 0 last. The popped word appears on a registered output one cycle after the strobe. A request the stack cannot honour is refused and changes nothing. Such a request is a push while full, a pop while empty, or both strobes in the same cycle. The refusal is reported by a one-cycle error pulse.

Top module: `regstack_lifo`

## Requirements
- R1: While reset is high and after it is released, the pointer is 0, the empty flag is 1, the full flag is 0, the error output is 0 and the read data is 0.
- R2: An accepted push (push high, pop low, full low) adds one to the pointer modulo 2^PTR_W in the next cycle, stores the write data at the new pointer value and clears the empty flag.
- R3: An accepted pop (pop high, push low, empty low) places the word stored at the current pointer on the read data in the next cycle and subtracts one from the pointer modulo 2^PTR_W.
- R4: The full flag is set by the push that brings the pointer to 0. This is the 2^PTR_W-th push from empty. Any accepted pop clears the full flag.
- R5: The empty flag is set by the pop that brings the pointer to 0.
- R6: A push while full leaves the pointer, the flags and the read data unchanged. The error output is 1 for exactly the next cycle.
- R7: A pop while empty leaves the pointer, the flags and the read data unchanged. The error output is 1 for exactly the next cycle.
- R8: Push and pop high in the same cycle is refused. Nothing is stored, the pointer, the flags and the read data keep their values, and the error output is 1 for the next cycle.
- R9: The read data keeps its value in every cycle that follows no accepted pop.
- R10: After the stack is filled to all 2^PTR_W words, emptying it returns the words in the reverse order of their pushes.
- R11: The full and empty flags are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Push request strobe |
| pop | input | 1 | Pop request strobe |
| wdata | input | DATA_W | Word to push |
| rdata | output | DATA_W | Word returned by the last accepted pop |
| sp | output | PTR_W | Stack pointer |
| full | output | 1 | Stack holds 2^PTR_W words |
| empty | output | 1 | Stack holds no words |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The bench builds the block with its default parameters: 8-bit words and a 6-bit pointer. A plain loop of 64 pushes is therefore enough to drive the pointer through its wrap to 0. That exercises the full flag and the slot-0 write, which only the last push ever uses. With 8-bit words, every one of the 64 pushed values can be made distinct. The pop loop then catches any reversal or misaddressing of the stored order. This includes the read of slot 0 and the step from 0 back to 63.

// File: rtl/regstack_pkg.sv
package regstack_pkg;

  typedef enum logic [1:0] {
    REQ_IDLE = 2'd0,
    REQ_PUSH = 2'd1,
    REQ_POP  = 2'd2,
    REQ_BAD  = 2'd3
  } req_e;

  // Classifies the strobes against the current flags.
  function automatic req_e classify(input logic push, input logic pop,
                                    input logic full, input logic empty);
    if (push && pop)             return REQ_BAD;
    else if (push && full)       return REQ_BAD;
    else if (pop && empty)       return REQ_BAD;
    else if (push)               return REQ_PUSH;
    else if (pop)                return REQ_POP;
    else                         return REQ_IDLE;
  endfunction

endpackage

// File: rtl/regstack_ctrl.sv
module regstack_ctrl #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic             rd_en,
  output logic [PTR_W-1:0] rd_addr,
  output logic [PTR_W-1:0] sp,
  output logic             full,
  output logic             empty,
  output logic             err
);
  import regstack_pkg::*;

  logic [PTR_W-1:0] sp_q, sp_up, sp_dn;
  logic             full_q, empty_q, err_q;
  req_e             req;

  assign sp_up = sp_q + PTR_W'(1);
  assign sp_dn = sp_q - PTR_W'(1);
  assign req   = classify(push, pop, full_q, empty_q);

  // Memory side: write goes to the incremented pointer, read uses the current one.
  assign wr_en   = (req == REQ_PUSH);
  assign wr_addr = sp_up;
  assign rd_en   = (req == REQ_POP);
  assign rd_addr = sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      err_q <= (req == REQ_BAD);
      unique case (req)
        REQ_PUSH: begin
          sp_q    <= sp_up;
          full_q  <= (sp_up == '0);
          empty_q <= 1'b0;
        end
        REQ_POP: begin
          sp_q    <= sp_dn;
          empty_q <= (sp_dn == '0);
          full_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign sp    = sp_q;
  assign full  = full_q;
  assign empty = empty_q;
  assign err   = err_q;

endmodule

// File: rtl/regstack_mem.sv
module regstack_mem #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rd_q;

  // Array write without reset so a RAM primitive can be inferred.
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // Registered read port with synchronous reset on the output register only.
  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= store[rd_addr];
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/regstack_lifo.sv
module regstack_lifo #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [PTR_W-1:0]  sp,
  output logic              full,
  output logic              empty,
  output logic              err
);
  logic             wr_en, rd_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;

  regstack_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .push    (push),
    .pop     (pop),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .sp      (sp),
    .full    (full),
    .empty   (empty),
    .err     (err)
  );

  regstack_mem #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wdata),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rdata)
  );

endmodule

// File: rtl/regstack_lifo_chk.sv
module regstack_lifo_chk #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              push,
  input logic              pop,
  input logic [DATA_W-1:0] rdata,
  input logic [PTR_W-1:0]  sp,
  input logic              full,
  input logic              empty,
  input logic              err
);
  localparam logic [PTR_W-1:0] TOP = {PTR_W{1'b1}};

  logic do_push, do_pop, bad;
  assign do_push = push && !pop && !full;
  assign do_pop  = pop && !push && !empty;
  assign bad     = (push && pop) || (push && full) || (pop && empty);

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (rst)
    do_push |=> (sp == PTR_W'($past(sp) + 1'b1)) && !empty);

  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (rst)
    do_pop |=> (sp == PTR_W'($past(sp) - 1'b1)) && !full);

  // R4
  full_set_chk: assert property (@(posedge clk) disable iff (rst)
    (do_push && sp == TOP) |=> full);

  // R5
  empty_set_chk: assert property (@(posedge clk) disable iff (rst)
    (do_pop && sp == PTR_W'(1)) |=> empty);

  // R6
  push_full_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full) |=> err && $stable(sp) && full && $stable(rdata));

  // R7
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> err && $stable(sp) && empty && $stable(rdata));

  // R8
  dual_req_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> err && $stable(sp) && $stable(full) && $stable(empty));

  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !bad |=> !err);

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !do_pop |=> $stable(rdata));

  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

endmodule

bind regstack_lifo regstack_lifo_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .push  (push),
  .pop   (pop),
  .rdata (rdata),
  .sp    (sp),
  .full  (full),
  .empty (empty),
  .err   (err)
);

// File: tb/regstack_lifo_bench.sv
module regstack_lifo_bench;
  localparam int DW = 8;
  localparam int PW = 6;
  localparam int NV = 9;
  // {push, pop, wdata, exp_rdata, exp_sp, exp_full, exp_empty, exp_err}
  localparam int VW = 2 + DW + DW + PW + 3;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'hA5, 8'h00, 6'd1, 1'b0, 1'b0, 1'b0},  // R2 push
    {1'b1, 1'b0, 8'h3C, 8'h00, 6'd2, 1'b0, 1'b0, 1'b0},  // R2 push
    {1'b0, 1'b1, 8'h00, 8'h3C, 6'd1, 1'b0, 1'b0, 1'b0},  // R3 pop
    {1'b1, 1'b1, 8'hFF, 8'h3C, 6'd1, 1'b0, 1'b0, 1'b1},  // R8 both
    {1'b0, 1'b1, 8'h00, 8'hA5, 6'd0, 1'b0, 1'b1, 1'b0},  // R5 pop to empty
    {1'b0, 1'b1, 8'h00, 8'hA5, 6'd0, 1'b0, 1'b1, 1'b1},  // R7 pop empty
    {1'b0, 1'b0, 8'h00, 8'hA5, 6'd0, 1'b0, 1'b1, 1'b0},  // R9 idle
    {1'b1, 1'b0, 8'h77, 8'hA5, 6'd1, 1'b0, 1'b0, 1'b0},  // R9 push keeps rdata
    {1'b0, 1'b1, 8'h00, 8'h77, 6'd0, 1'b0, 1'b1, 1'b0}   // R3 pop
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push = 1'b0, pop = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [PW-1:0] sp;
  logic          full, empty, err;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  regstack_lifo #(.DATA_W(DW), .PTR_W(PW)) u_regstack_lifo (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .wdata(wdata),
    .rdata(rdata), .sp(sp), .full(full), .empty(empty), .err(err)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic p, input logic q, input logic [DW-1:0] d);
    push = p; pop = q; wdata = d;
    @(negedge clk);
    push = 1'b0; pop = 1'b0; wdata = '0;
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 5 + 3);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sp", 32'(sp), 0);
    check("R1 empty", 32'(empty), 1);
    check("R1 full", 32'(full), 0);
    check("R1 err", 32'(err), 0);
    check("R1 rdata", 32'(rdata), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      step(e[VW-1], e[VW-2], e[VW-3 -: DW]);
      check($sformatf("vec%0d rdata", v), 32'(rdata), 32'(e[PW+3+DW-1 -: DW]));
      check($sformatf("vec%0d sp", v), 32'(sp), 32'(e[PW+2 -: PW]));
      check($sformatf("vec%0d full", v), 32'(full), 32'(e[2]));
      check($sformatf("vec%0d empty", v), 32'(empty), 32'(e[1]));
      check($sformatf("vec%0d err", v), 32'(err), 32'(e[0]));
    end

    // R4 fill all 64 slots; the pointer wraps to 0 on the last push
    for (int i = 0; i < 64; i++) begin
      step(1'b1, 1'b0, pat(i));
      check("R2 fill sp", 32'(sp), 32'((i + 1) % 64));
      check("R4 fill full", 32'(full), (i == 63) ? 1 : 0);
    end
    check("R2 fill empty", 32'(empty), 0);

    // R6 push while full is refused
    step(1'b1, 1'b0, 8'hEE);
    check("R6 err", 32'(err), 1);
    check("R6 sp", 32'(sp), 0);
    check("R6 full", 32'(full), 1);
    step(1'b0, 1'b0, '0);
    check("R6 err pulse", 32'(err), 0);

    // R10 drain in reverse order
    for (int j = 0; j < 64; j++) begin
      step(1'b0, 1'b1, '0);
      check("R10 rdata", 32'(rdata), 32'(pat(63 - j)));
      check("R3 drain sp", 32'(sp), 32'(63 - j));
      check("R4 full cleared", 32'(full), 0);
      check("R5 drain empty", 32'(empty), (j == 63) ? 1 : 0);
    end

    // R7 pop while empty is refused
    step(1'b0, 1'b1, '0);
    check("R7 err", 32'(err), 1);
    check("R7 rdata", 32'(rdata), 32'(pat(0)));
    check("R7 sp", 32'(sp), 0);

    // R1 reset in the middle of use
    step(1'b1, 1'b0, 8'h11);
    step(1'b1, 1'b0, 8'h22);
    step(1'b0, 1'b1, '0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid sp", 32'(sp), 0);
    check("R1 mid empty", 32'(empty), 1);
    check("R1 mid rdata", 32'(rdata), 0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule